// File: doc/BRIEF.md
# XGMII Transmit Framer

The framer turns a stream of whole 64-bit words from a first-word-fall-through FIFO into Ethernet frames on a 64-bit XGMII transmit bus with one control bit per byte lane. Lane 0 is `txd[7:0]` with control bit `txc[0]`. Lane 7 is `txd[63:56]` with control bit `txc[7]`. Between frames it drives idle characters. When the FIFO reports a word, the framer opens a frame with a single start word. That word carries the start character, the preamble and the start-of-frame delimiter. The framer then streams payload words with their byte order reversed. It closes the frame with a terminate word as soon as the FIFO runs dry.

Frame boundaries come only from the FIFO's valid flag. A frame lasts exactly as long as valid stays high, and it always ends on a word boundary. The read strobe is combinational from the framer state and the valid flag, so a FIFO word is popped in the same cycle it is captured. Every other output is registered. CRC, padding, gap shaping and partial final words are left to other blocks.

Top module: `xgtx_framer`

## Requirements
- R1: While no frame is in progress, every lane of `txd` carries 0x07, `txc` is 8'hFF and `rd_en` is low.
- R2: The cycle after `rd_valid` is seen high with no frame running, `txd` shows the start word and `txc` is 8'b00000001. In the start word, lane 0 is 0xFB, lanes 1 to 6 are 0x55 and lane 7 is 0xD5.
- R3: `rd_en` is high in the start cycle and in each frame cycle while `rd_valid` is high. It is never high while `rd_valid` is low, and it is never high outside those states.
- R4: Payload bytes are reversed. Input byte i (byte 0 = `rd_data[7:0]`) appears in lane 7-i. For example, 64'h0123456789ABCDEF is sent as 64'hEFCDAB8967452301.
- R5: Each word read with `rd_en` high appears exactly once on `txd`, in the next cycle, in order, with `txc` = 8'h00.
- R6: In the cycle after `rd_valid` is low during a frame, `txd` carries the terminate word and `txc` = 8'hFF. The terminate word has 0xFD in lane 0 and 0x07 in lanes 1 to 7.
- R7: After a terminate word, if `rd_valid` is high, the next word is a start word with no idle word in between. Idle words appear only while `rd_valid` stays low.
- R8: A synchronous active-high `rst` returns the framer to the idle state of R1 at the next clock edge, even in the middle of a frame.
- R9: If `rd_valid` is low during the start cycle, nothing is read. The next word is a terminate word, which gives an empty frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rd_en | output | 1 | FIFO read strobe; pops the presented word |
| rd_data | input | 64 | Word presented by the FIFO |
| rd_valid | input | 1 | FIFO has a word on `rd_data` |
| txd | output | 64 | XGMII transmit data, lane 0 in bits 7:0 |
| txc | output | 8 | XGMII transmit control, one bit per lane |

## Verification
The bench builds the framer with its default parameters: eight 8-bit lanes and the reversed lane map. With these values the 64-bit example word can be checked exactly, and the start word holds a full run of six preamble lanes. Frames of one, two and five words exercise the payload path. Back-to-back frames, an empty frame and a reset in mid-frame reach the state transitions that a single frame never visits.

// File: rtl/xgtx_pkg.sv
package xgtx_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_START = 2'd1,
      ST_DATA  = 2'd2,
      ST_TERM  = 2'd3
   } xgtx_state_e;

   localparam logic [7:0] CH_IDLE  = 8'h07;
   localparam logic [7:0] CH_START = 8'hFB;
   localparam logic [7:0] CH_TERM  = 8'hFD;
   localparam logic [7:0] CH_PRE   = 8'h55;
   localparam logic [7:0] CH_SFD   = 8'hD5;

   function automatic xgtx_state_e next_state(input xgtx_state_e cur, input logic valid);
      xgtx_state_e nxt;
      case (cur)
         ST_IDLE, ST_TERM:  nxt = valid ? ST_START : ST_IDLE;
         ST_START, ST_DATA: nxt = valid ? ST_DATA  : ST_TERM;
         default:           nxt = ST_IDLE;
      endcase
      return nxt;
   endfunction

endpackage

// File: rtl/xgtx_lane_map.sv
module xgtx_lane_map #(
   parameter int LANES   = 8,
   parameter int LANE_W  = 8,
   parameter bit REVERSE = 1'b1,
   localparam int DW     = LANES * LANE_W
) (
   input  logic [DW-1:0] din,
   output logic [DW-1:0] dout
);

   generate
      if (REVERSE) begin : g_rev
         for (genvar i = 0; i < LANES; i++) begin : g_lane
            assign dout[(LANES-1-i)*LANE_W +: LANE_W] = din[i*LANE_W +: LANE_W];
         end
      end else begin : g_straight
         assign dout = din;
      end
   endgenerate

endmodule

// File: rtl/xgtx_ctrl.sv
module xgtx_ctrl
   import xgtx_pkg::*;
(
   input  logic        clk,
   input  logic        rst,
   input  logic        rd_valid,
   output xgtx_state_e state,
   output logic        rd_en
);

   xgtx_state_e state_q;

   always_ff @(posedge clk) begin
      if (rst) state_q <= ST_IDLE;
      else     state_q <= next_state(state_q, rd_valid);
   end

   assign state = state_q;
   assign rd_en = ((state_q == ST_START) || (state_q == ST_DATA)) && rd_valid;

endmodule

// File: rtl/xgtx_word_gen.sv
module xgtx_word_gen
   import xgtx_pkg::*;
#(
   parameter int LANES  = 8,
   parameter int LANE_W = 8,
   localparam int DW    = LANES * LANE_W
) (
   input  logic          clk,
   input  logic          rst,
   input  xgtx_state_e   state,
   input  logic          rd_valid,
   input  logic [DW-1:0] payload,
   output logic [DW-1:0] txd,
   output logic [LANES-1:0] txc
);

   logic [DW-1:0] w_idle, w_start, w_term;

   generate
      for (genvar i = 0; i < LANES; i++) begin : g_const
         assign w_idle[i*LANE_W +: LANE_W] = CH_IDLE;
         if (i == 0) begin : g_l0
            assign w_start[i*LANE_W +: LANE_W] = CH_START;
            assign w_term [i*LANE_W +: LANE_W] = CH_TERM;
         end else if (i == LANES-1) begin : g_last
            assign w_start[i*LANE_W +: LANE_W] = CH_SFD;
            assign w_term [i*LANE_W +: LANE_W] = CH_IDLE;
         end else begin : g_mid
            assign w_start[i*LANE_W +: LANE_W] = CH_PRE;
            assign w_term [i*LANE_W +: LANE_W] = CH_IDLE;
         end
      end
   endgenerate

   localparam logic [LANES-1:0] C_ALL   = '1;
   localparam logic [LANES-1:0] C_NONE  = '0;
   localparam logic [LANES-1:0] C_LANE0 = LANES'(1);

   logic [DW-1:0]    d_nxt;
   logic [LANES-1:0] c_nxt;

   always_comb begin
      d_nxt = w_idle;
      c_nxt = C_ALL;
      case (state)
         ST_IDLE, ST_TERM: begin
            if (rd_valid) begin
               d_nxt = w_start;
               c_nxt = C_LANE0;
            end
         end
         ST_START, ST_DATA: begin
            if (rd_valid) begin
               d_nxt = payload;
               c_nxt = C_NONE;
            end else begin
               d_nxt = w_term;
               c_nxt = C_ALL;
            end
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         txd <= w_idle;
         txc <= C_ALL;
      end else begin
         txd <= d_nxt;
         txc <= c_nxt;
      end
   end

endmodule

// File: rtl/xgtx_framer.sv
module xgtx_framer
   import xgtx_pkg::*;
#(
   parameter int LANES         = 8,
   parameter int LANE_W        = 8,
   parameter bit REVERSE_LANES = 1'b1,
   localparam int DW           = LANES * LANE_W
) (
   input  logic             clk,
   input  logic             rst,
   output logic             rd_en,
   input  logic [DW-1:0]    rd_data,
   input  logic             rd_valid,
   output logic [DW-1:0]    txd,
   output logic [LANES-1:0] txc
);

   generate
      if (LANES < 3) begin : g_bad_lanes
         $error("xgtx_framer: LANES must be at least 3");
      end
      if (LANE_W != 8) begin : g_bad_width
         $error("xgtx_framer: LANE_W must be 8 for XGMII characters");
      end
   endgenerate

   xgtx_state_e   state;
   logic [DW-1:0] payload;

   xgtx_ctrl u_ctrl (
      .clk      (clk),
      .rst      (rst),
      .rd_valid (rd_valid),
      .state    (state),
      .rd_en    (rd_en)
   );

   xgtx_lane_map #(.LANES(LANES), .LANE_W(LANE_W), .REVERSE(REVERSE_LANES)) u_map (
      .din  (rd_data),
      .dout (payload)
   );

   xgtx_word_gen #(.LANES(LANES), .LANE_W(LANE_W)) u_gen (
      .clk      (clk),
      .rst      (rst),
      .state    (state),
      .rd_valid (rd_valid),
      .payload  (payload),
      .txd      (txd),
      .txc      (txc)
   );

endmodule

// File: rtl/xgtx_framer_chk.sv
module xgtx_framer_chk #(
   parameter int LANES         = 8,
   parameter int LANE_W        = 8,
   parameter bit REVERSE_LANES = 1'b1,
   localparam int DW           = LANES * LANE_W
) (
   input logic             clk,
   input logic             rst,
   input logic             rd_en,
   input logic [DW-1:0]    rd_data,
   input logic             rd_valid,
   input logic [DW-1:0]    txd,
   input logic [LANES-1:0] txc
);

   function automatic logic [DW-1:0] lane_swap(input logic [DW-1:0] w);
      logic [DW-1:0] r;
      for (int i = 0; i < LANES; i++) begin
         if (REVERSE_LANES) r[(LANES-1-i)*LANE_W +: LANE_W] = w[i*LANE_W +: LANE_W];
         else               r[i*LANE_W +: LANE_W]           = w[i*LANE_W +: LANE_W];
      end
      return r;
   endfunction

   localparam logic [LANES-1:0] C_ALL  = '1;
   localparam logic [LANES-1:0] C_NONE = '0;
   localparam logic [LANES-1:0] C_L0   = LANES'(1);

   AST_RESET_IDLE: assert property (@(posedge clk)
      rst |=> (txc == C_ALL) && (txd[7:0] == 8'h07) && !rd_en); // R8

   AST_CTRL_NO_READ: assert property (@(posedge clk) disable iff (rst)
      (txc == C_ALL) |-> !rd_en); // R1

   AST_READ_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
      rd_en |-> rd_valid); // R3

   AST_READ_START: assert property (@(posedge clk) disable iff (rst)
      $rose(rd_en) |-> (txc == C_L0) && (txd[7:0] == 8'hFB)); // R2

   AST_PAYLOAD_PASS: assert property (@(posedge clk) disable iff (rst)
      rd_en |=> (txc == C_NONE) && (txd == lane_swap($past(rd_data)))); // R5

   AST_DRY_TERM: assert property (@(posedge clk) disable iff (rst)
      ((txc == C_NONE) && !rd_valid) |=> (txc == C_ALL) && (txd[7:0] == 8'hFD)); // R6

   AST_START_FOLLOWS_VALID: assert property (@(posedge clk) disable iff (rst)
      ((txc == C_ALL) && rd_valid) |=> (txc == C_L0)); // R7

   AST_EMPTY_FRAME: assert property (@(posedge clk) disable iff (rst)
      ((txc == C_L0) && !rd_valid) |=> (txc == C_ALL) && (txd[7:0] == 8'hFD)); // R9

endmodule

bind xgtx_framer xgtx_framer_chk #(
   .LANES(LANES), .LANE_W(LANE_W), .REVERSE_LANES(REVERSE_LANES)
) u_chk (
   .clk(clk), .rst(rst), .rd_en(rd_en), .rd_data(rd_data),
   .rd_valid(rd_valid), .txd(txd), .txc(txc)
);

// File: tb/sim_xgtx_framer.sv
module sim_xgtx_framer;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        rd_en;
   logic [63:0] rd_data = '0;
   logic        rd_valid = 1'b0;
   logic [63:0] txd;
   logic [7:0]  txc;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   localparam logic [63:0] W_IDLE  = {8{8'h07}};
   localparam logic [63:0] W_START = {8'hD5, {6{8'h55}}, 8'hFB};
   localparam logic [63:0] W_TERM  = {{7{8'h07}}, 8'hFD};

   xgtx_framer u0 (
      .clk(clk), .rst(rst), .rd_en(rd_en), .rd_data(rd_data),
      .rd_valid(rd_valid), .txd(txd), .txc(txc)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic logic [63:0] swap_bytes(input logic [63:0] w);
      logic [63:0] r;
      for (int i = 0; i < 8; i++) r[8*(7-i) +: 8] = w[8*i +: 8];
      return r;
   endfunction

   function automatic logic [63:0] pat(input logic [63:0] base, input int k);
      return base + 64'(k) * 64'h1111_2222_3333_4445;
   endfunction

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic chk(input string req, input logic [63:0] act_d, input logic [63:0] exp_d,
                      input logic [7:0] act_c, input logic [7:0] exp_c,
                      input logic act_e, input logic exp_e);
      checks++;
      if (act_d !== exp_d || act_c !== exp_c || act_e !== exp_e) begin
         errors++;
         $display("FAIL %s: txd=%h txc=%h rd_en=%b expected txd=%h txc=%h rd_en=%b",
                  req, act_d, act_c, act_e, exp_d, exp_c, exp_e);
      end
   endtask

   // Sends one frame of n words; entered in an idle or terminate cycle.
   task automatic run_frame(input int n, input logic [63:0] base, input string tag);
      rd_valid = 1'b1;
      rd_data  = pat(base, 0);
      #1;
      chk({tag, " R3 no read before start"}, txd, txd, txc, txc, rd_en, 1'b0);
      tick();
      chk({tag, " R2 start word"}, txd, W_START, txc, 8'h01, rd_en, 1'b1);
      for (int k = 0; k < n; k++) begin
         tick();
         if (k + 1 < n) rd_data = pat(base, k + 1);
         else begin rd_valid = 1'b0; rd_data = '0; end
         #1;
         chk({tag, " R4 R5 payload"}, txd, swap_bytes(pat(base, k)), txc, 8'h00,
             rd_en, (k + 1 < n));
      end
      tick();
      chk({tag, " R6 terminate"}, txd, W_TERM, txc, 8'hFF, rd_en, 1'b0);
   endtask

   task automatic t_reset();
      rst = 1'b1;
      tick(); tick();
      rst = 1'b0;
      #1;
      chk("R1 R8 idle after reset", txd, W_IDLE, txc, 8'hFF, rd_en, 1'b0);
      tick();
      chk("R1 idle holds", txd, W_IDLE, txc, 8'hFF, rd_en, 1'b0);
   endtask

   task automatic t_example();
      rd_valid = 1'b1;
      rd_data  = 64'h0123456789ABCDEF;
      #1;
      tick();
      chk("R2 R3 start", txd, W_START, txc, 8'h01, rd_en, 1'b1);
      tick();
      rd_data = 64'hBBBBBBBBBBBBBBBB;
      #1;
      chk("R4 example reversal", txd, 64'hEFCDAB8967452301, txc, 8'h00, rd_en, 1'b1);
      tick();
      rd_valid = 1'b0;
      rd_data  = '0;
      #1;
      chk("R5 second word", txd, 64'hBBBBBBBBBBBBBBBB, txc, 8'h00, rd_en, 1'b0);
      tick();
      chk("R6 terminate word", txd, W_TERM, txc, 8'hFF, rd_en, 1'b0);
      tick();
      chk("R1 R7 idle after term", txd, W_IDLE, txc, 8'hFF, rd_en, 1'b0);
   endtask

   task automatic t_back_to_back();
      run_frame(1, 64'h0011_2233_4455_6677, "b2b-a");
      run_frame(5, 64'h8899_AABB_CCDD_EEFF, "b2b-b R7");
      run_frame(2, 64'hDEAD_BEEF_0BAD_F00D, "b2b-c R7");
      tick();
      chk("R7 idle after valid low", txd, W_IDLE, txc, 8'hFF, rd_en, 1'b0);
   endtask

   task automatic t_empty();
      rd_valid = 1'b1;
      rd_data  = 64'hFEDC_BA98_7654_3210;
      tick();
      rd_valid = 1'b0;
      #1;
      chk("R9 no read in empty start", txd, W_START, txc, 8'h01, rd_en, 1'b0);
      tick();
      chk("R9 empty frame terminate", txd, W_TERM, txc, 8'hFF, rd_en, 1'b0);
      tick();
      chk("R9 R1 idle after empty", txd, W_IDLE, txc, 8'hFF, rd_en, 1'b0);
   endtask

   task automatic t_mid_reset();
      rd_valid = 1'b1;
      rd_data  = 64'h1357_9BDF_0246_8ACE;
      tick();
      tick();
      rst = 1'b1;
      tick();
      rst = 1'b0;
      rd_valid = 1'b0;
      #1;
      chk("R8 reset mid-frame", txd, W_IDLE, txc, 8'hFF, rd_en, 1'b0);
      tick();
      chk("R8 R1 idle stays", txd, W_IDLE, txc, 8'hFF, rd_en, 1'b0);
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      t_reset();
      t_example();
      t_back_to_back();
      t_empty();
      t_mid_reset();
      run_frame(3, 64'hA5A5_5A5A_0F0F_F0F0, "after-reset");
      tick();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule